// File: doc/BRIEF.md
# Serial LED Status Shift-Out Engine

This block sends a hub's status to a row of LEDs over four wires. Once per display frame it fires a burst of exactly sixteen clock pulses on `led_ck_o`. It shifts three parallel data lanes on `led_o[2:0]` alongside those pulses. External serial-in parallel-out shift registers turn the lanes into LED drive levels. Every line is active low: a data bit of 0 lights its LED, and the clock rests high between bursts. Data moves on the falling clock edge, so the external registers capture settled data on the rising edge.

The lanes carry five kinds of status. The first is per-port partition, jabber and activity. The second is global partition and a RAM self-test failure flag. The third is a collision flag for each of the two line speeds. Last are two utilization bars, one for each speed domain. A bar comes from counting the cycles in which carrier is present inside a fixed measurement window. It is shown as an 8-step thermometer. Inter-frame gaps carry no carrier, so they never add to the busy count and a real link cannot fill the whole bar. After reset the engine first runs a lamp test of four frames: all on, all off, all on, all off. It then moves to live status. The status inputs are captured in the cycle that starts a burst. All sixteen bits of a burst therefore describe a single instant.

Top module: `led_serial_status`

## Requirements
- R1: Each burst has exactly 16 rising edges of `led_ck_o`. Outside a burst `led_ck_o` stays high.
- R2: A burst begins in the first clock cycle after reset is released and again every `FRAME_CYC` cycles. Its first clock edge is a fall.
- R3: Each half of an LED clock period lasts `CK_HALF` system cycles. During a burst, `led_o` changes only together with a falling `led_ck_o`, and it holds while the clock is high.
- R4: Lane `led_o[0]` carries these bits in rising-edge order. D0..D4 are partition for ports 0..4. D5..D9 are jabber for ports 0..4. D10..D15 are 1.
- R5: Lane `led_o[1]` carries these bits. D0..D4 are activity for ports 0..4. D5..D12 are low-speed utilization steps 0..7. D13 is low-speed collision. D14 is global partition. D15 is 1.
- R6: Lane `led_o[2]` carries these bits. D0..D7 are high-speed utilization steps 0..7. D8 is high-speed collision. D9 is RAM test fail. D10..D15 are 1.
- R7: Every status bit is shifted out inverted, so an asserted flag is sent as 0. The 16 bits of a burst reflect the inputs at the burst's starting cycle, even if the inputs change during the burst.
- R8: The measurement window is `WIN_CYC` cycles long and starts at reset release. Utilization step k is on when 8 × (carrier cycles in the last completed window) ≥ (k+1) × `WIN_CYC`. All steps are off until the first window completes.
- R9: The first four bursts after reset send all 0, then all 1, then all 0, then all 1 on every lane. Live status starts at the fifth burst.
- R10: While reset is asserted, `led_ck_o` is 1 and `led_o` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| part_i | input | NPORT | Per-port partition flags |
| jab_i | input | NPORT | Per-port jabber flags |
| act_i | input | NPORT | Per-port activity flags |
| col_lo_i | input | 1 | Low-speed global collision |
| col_hi_i | input | 1 | High-speed global collision |
| gpart_i | input | 1 | Global partition flag |
| ram_fail_i | input | 1 | Buffer RAM test failure flag |
| crs_lo_i | input | 1 | Low-speed carrier present |
| crs_hi_i | input | 1 | High-speed carrier present |
| led_ck_o | output | 1 | Gated shift clock, idles high |
| led_o | output | 3 | Serial data lanes, active low |

## Verification
The bench shrinks the timing parameters to `FRAME_CYC` = 200, `WIN_CYC` = 64 and `CK_HALF` = 2. With these values the four lamp-test frames and more than a dozen live frames fit in a few thousand cycles. Several utilization windows complete before every live snapshot. Because the window length does not divide the frame length, window edges fall at different points relative to the snapshots. The longer half period lets the bench see each clock phase twice, so it can tell a data change on the rising edge apart from one on the falling edge. Carrier densities of zero and full exercise both ends of the bar, including the all-steps-on case.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  localparam int LANES = 3;
  localparam int BITS  = 16;
  localparam int STEPS = 8;
  typedef logic [BITS-1:0] lane_t;
endpackage

// File: rtl/led_frame_timer.sv
module led_frame_timer #(
  parameter int FRAME_CYC   = 3125000,
  parameter int TEST_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic frame_start_o,
  output logic test_on_o,
  output logic test_off_o
);
  localparam int FW = $clog2(FRAME_CYC);
  localparam int PW = $clog2(TEST_FRAMES + 1);

  logic [FW-1:0] cnt_q;
  logic [PW-1:0] phase_q;
  logic          in_test;

  assign frame_start_o = (cnt_q == '0);
  assign in_test       = (phase_q < PW'(TEST_FRAMES));
  assign test_on_o     = in_test && !phase_q[0];
  assign test_off_o    = in_test && phase_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      cnt_q <= (cnt_q == FW'(FRAME_CYC - 1)) ? '0 : cnt_q + 1'b1;
      if (frame_start_o && in_test) phase_q <= phase_q + 1'b1;
    end
  end

  // R9: once live, the lamp test never returns
  a_r9_test_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_test |=> !in_test);
  // R2: start is a single-cycle pulse
  a_r2_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
endmodule

// File: rtl/led_util_meter.sv
module led_util_meter
  import led_ser_pkg::*;
#(
  parameter int WIN_CYC = 2620000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             crs_i,
  output logic [STEPS-1:0] therm_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam int WW = $clog2(WIN_CYC);

  logic [WW-1:0]    wc_q;
  logic [CW-1:0]    bc_q;
  logic [CW-1:0]    tot;
  logic [CW+2:0]    scaled;
  logic [STEPS-1:0] therm_d;
  logic [STEPS-1:0] therm_q;
  logic             win_end;

  assign tot     = bc_q + CW'(crs_i);
  assign scaled  = {tot, 3'b000};
  assign win_end = (wc_q == WW'(WIN_CYC - 1));

  for (genvar k = 0; k < STEPS; k++) begin : g_thr
    localparam logic [CW+2:0] THR = (CW + 3)'((k + 1) * WIN_CYC);
    assign therm_d[k] = (scaled >= THR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q    <= '0;
      bc_q    <= '0;
      therm_q <= '0;
    end else if (win_end) begin
      wc_q    <= '0;
      bc_q    <= '0;
      therm_q <= therm_d;
    end else begin
      wc_q <= wc_q + 1'b1;
      bc_q <= tot;
    end
  end

  assign therm_o = therm_q;

  // R8: bar fills from step 0 upward with no gaps
  a_r8_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_q + 1'b1) & therm_q) == '0);
  // R8: bar only moves at a window boundary
  a_r8_hold_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(therm_q));
endmodule

// File: rtl/led_shift_out.sv
module led_shift_out
  import led_ser_pkg::*;
#(
  parameter int CK_HALF = 1,
  parameter int NPORT   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             test_on_i,
  input  logic             test_off_i,
  input  logic [NPORT-1:0] part_i,
  input  logic [NPORT-1:0] jab_i,
  input  logic [NPORT-1:0] act_i,
  input  logic             col_lo_i,
  input  logic             col_hi_i,
  input  logic             gpart_i,
  input  logic             ram_fail_i,
  input  logic [STEPS-1:0] util_lo_i,
  input  logic [STEPS-1:0] util_hi_i,
  output logic             led_ck_o,
  output logic [LANES-1:0] led_o
);
  localparam int HW = (CK_HALF > 1) ? $clog2(CK_HALF) : 1;
  localparam int PH = $clog2(2 * BITS);

  lane_t          word [LANES];
  lane_t          snap_q [LANES];
  logic           busy_q;
  logic [PH-1:0]  ph_q;
  logic [HW-1:0]  hc_q;

  // on-bit view: 1 = LED lit; inverted at the pins
  always_comb begin
    for (int l = 0; l < LANES; l++) word[l] = '0;
    word[0][NPORT-1:0]           = part_i;
    word[0][2*NPORT-1:NPORT]     = jab_i;
    word[1][NPORT-1:0]           = act_i;
    word[1][NPORT+STEPS-1:NPORT] = util_lo_i;
    word[1][NPORT+STEPS]         = col_lo_i;
    word[1][NPORT+STEPS+1]       = gpart_i;
    word[2][STEPS-1:0]           = util_hi_i;
    word[2][STEPS]               = col_hi_i;
    word[2][STEPS+1]             = ram_fail_i;
    for (int l = 0; l < LANES; l++) begin
      if (test_on_i)  word[l] = '1;
      if (test_off_i) word[l] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      hc_q   <= '0;
      for (int l = 0; l < LANES; l++) snap_q[l] <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        hc_q   <= '0;
        for (int l = 0; l < LANES; l++) snap_q[l] <= word[l];
      end
    end else if (hc_q == HW'(CK_HALF - 1)) begin
      hc_q <= '0;
      if (ph_q == PH'(2 * BITS - 1)) busy_q <= 1'b0;
      else                           ph_q   <= ph_q + 1'b1;
    end else begin
      hc_q <= hc_q + 1'b1;
    end
  end

  assign led_ck_o = !busy_q || ph_q[0];
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign led_o[l] = !(busy_q && snap_q[l][ph_q[PH-1:1]]);
  end

  a_r1_ck_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> led_ck_o);
  a_r2_frame_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r3_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && led_ck_o && $past(led_ck_o)) |-> $stable(led_o));
  a_r3_no_change_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $rose(led_ck_o)) |-> $stable(led_o));
  a_r10_idle_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (led_o == '1));
endmodule

// File: rtl/led_serial_status.sv
module led_serial_status
  import led_ser_pkg::*;
#(
  parameter int NPORT     = 5,
  parameter int FRAME_CYC = 3125000,
  parameter int WIN_CYC   = 2620000,
  parameter int CK_HALF   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] part_i,
  input  logic [NPORT-1:0] jab_i,
  input  logic [NPORT-1:0] act_i,
  input  logic             col_lo_i,
  input  logic             col_hi_i,
  input  logic             gpart_i,
  input  logic             ram_fail_i,
  input  logic             crs_lo_i,
  input  logic             crs_hi_i,
  output logic             led_ck_o,
  output logic [2:0]       led_o
);
  logic             frame_start;
  logic             test_on;
  logic             test_off;
  logic [1:0]       crs;
  logic [STEPS-1:0] util [2];

  assign crs = {crs_hi_i, crs_lo_i};

  led_frame_timer #(
    .FRAME_CYC  (FRAME_CYC),
    .TEST_FRAMES(4)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_o(frame_start),
    .test_on_o    (test_on),
    .test_off_o   (test_off)
  );

  for (genvar s = 0; s < 2; s++) begin : g_meter
    led_util_meter #(.WIN_CYC(WIN_CYC)) u_meter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .crs_i  (crs[s]),
      .therm_o(util[s])
    );
  end

  led_shift_out #(
    .CK_HALF(CK_HALF),
    .NPORT  (NPORT)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start),
    .test_on_i (test_on),
    .test_off_i(test_off),
    .part_i    (part_i),
    .jab_i     (jab_i),
    .act_i     (act_i),
    .col_lo_i  (col_lo_i),
    .col_hi_i  (col_hi_i),
    .gpart_i   (gpart_i),
    .ram_fail_i(ram_fail_i),
    .util_lo_i (util[0]),
    .util_hi_i (util[1]),
    .led_ck_o  (led_ck_o),
    .led_o     (led_o)
  );
endmodule

// File: tb/led_serial_status_tb.sv
module led_serial_status_tb;
  localparam int NP    = 5;
  localparam int FRAME = 200;
  localparam int WIN   = 64;
  localparam int CKH   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] part = '0, jab = '0, act = '0;
  logic col_lo = 0, col_hi = 0, gpart = 0, ram_fail = 0;
  logic crs_lo = 0, crs_hi = 0;
  logic led_ck;
  logic [2:0] led;

  int checks = 0, fails = 0;
  int e = 0, wc = 0, c_lo = 0, c_hi = 0;
  int dens_lo = 100, dens_hi = 0;
  logic [7:0] m_lo = '0, m_hi = '0, s_lo = '0, s_hi = '0;

  always #5 clk = ~clk;

  led_serial_status #(
    .NPORT(NP), .FRAME_CYC(FRAME), .WIN_CYC(WIN), .CK_HALF(CKH)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .part_i(part), .jab_i(jab), .act_i(act),
    .col_lo_i(col_lo), .col_hi_i(col_hi), .gpart_i(gpart), .ram_fail_i(ram_fail),
    .crs_lo_i(crs_lo), .crs_hi_i(crs_hi), .led_ck_o(led_ck), .led_o(led)
  );

  function automatic logic [7:0] therm_f(int cnt);
    logic [7:0] t;
    for (int k = 0; k < 8; k++) t[k] = (cnt * 8 >= (k + 1) * WIN);
    return t;
  endfunction

  // model of the utilization windows (R8) and snapshot points (R2)
  always @(posedge clk) begin
    if (rst_n) begin
      if (e % FRAME == 0) begin s_lo = m_lo; s_hi = m_hi; end
      c_lo += int'(crs_lo);
      c_hi += int'(crs_hi);
      if (wc == WIN - 1) begin
        m_lo = therm_f(c_lo); m_hi = therm_f(c_hi);
        c_lo = 0; c_hi = 0; wc = 0;
      end else wc++;
      e++;
    end
  end

  always @(negedge clk) begin
    crs_lo <= (int'($urandom % 100) < dens_lo);
    crs_hi <= (int'($urandom % 100) < dens_hi);
  end

  task automatic chk(bit ok, string req, logic [15:0] act_v, logic [15:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic rnd_status();
    part = NP'($urandom); jab = NP'($urandom); act = NP'($urandom);
    col_lo = 1'($urandom); col_hi = 1'($urandom);
    gpart = 1'($urandom); ram_fail = 1'($urandom);
  endtask

  // expected lanes, active low (R4, R5, R6, R7)
  function automatic logic [2:0][15:0] exp_word();
    logic [2:0][15:0] w;
    w = '0;
    w[0][4:0] = part;  w[0][9:5] = jab;
    w[1][4:0] = act;   w[1][12:5] = s_lo; w[1][13] = col_lo; w[1][14] = gpart;
    w[2][7:0] = s_hi;  w[2][8] = col_hi;  w[2][9] = ram_fail;
    return ~w;
  endfunction

  task automatic capture(int fr, bit flip);
    logic [2:0][15:0] got, expv;
    logic [2:0] last;
    int idx, rises_extra, start_e, ns;
    bit prev, held;
    do @(negedge clk); while (led_ck !== 1'b0);
    start_e = e;
    if (fr < 4) expv = (fr % 2 == 0) ? '0 : '1;
    else        expv = exp_word();
    got = '1; idx = 0; prev = 1'b0; held = 1'b1; last = led; ns = 0;
    while (idx < 16) begin
      @(negedge clk);
      ns++;
      if (flip && ns == 10) rnd_status();
      if (!prev && led_ck) begin
        for (int l = 0; l < 3; l++) got[l][idx] = led[l];
        last = led; idx++;
      end else if (prev && led_ck && led !== last) held = 1'b0;
      prev = led_ck;
      if (ns > 8 * CKH * 16) break;
    end
    rises_extra = 0;
    repeat (4 * CKH) begin
      @(negedge clk);
      if (led_ck !== 1'b1) rises_extra++;
    end
    chk(start_e - 1 == fr * FRAME, "R2 burst start cycle", 16'(start_e - 1), 16'(fr * FRAME));
    chk(idx == 16 && rises_extra == 0, "R1 sixteen rises then idle high", 16'(idx), 16'd16);
    chk(held, "R3 data held while clock high", 16'(held), 16'd1);
    if (fr < 4) begin
      for (int l = 0; l < 3; l++)
        chk(got[l] === expv[l], "R9 lamp test pattern", got[l], expv[l]);
    end else begin
      chk(got[0] === expv[0], flip ? "R7 snapshot lane0" : "R4 lane0", got[0], expv[0]);
      chk(got[1] === expv[1], flip ? "R7 snapshot lane1" : "R5 lane1", got[1], expv[1]);
      chk(got[2] === expv[2], flip ? "R7 snapshot lane2" : "R6 lane2", got[2], expv[2]);
      chk({got[2][7:0], got[1][12:5]} === {expv[2][7:0], expv[1][12:5]}, "R8 utilization bars",
          {got[2][7:0], got[1][12:5]}, {expv[2][7:0], expv[1][12:5]});
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", e, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(led_ck === 1'b1, "R10 reset clock high", 16'(led_ck), 16'd1);
    chk(led === 3'b111, "R10 reset lanes dark", 16'(led), 16'h7);
    rst_n = 1'b1;
    for (int fr = 0; fr < 4; fr++) capture(fr, 1'b0);
    // directed: full low-speed carrier, no high-speed carrier, no flags
    capture(4, 1'b0);
    // directed: every flag asserted
    part = '1; jab = '1; act = '1; col_lo = 1; col_hi = 1; gpart = 1; ram_fail = 1;
    dens_lo = 0; dens_hi = 100;
    capture(5, 1'b0);
    for (int fr = 6; fr < 18; fr++) begin
      rnd_status();
      dens_lo = int'($urandom % 101);
      dens_hi = int'($urandom % 101);
      capture(fr, (fr % 4 == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule